// File: doc/BRIEF.md
# Runtime-Programmable AND-OR Logic Array

This block is an AND-OR logic array whose function is held in configuration registers and can be changed while the chip runs. Each of the `N_IN` inputs is offered to the product plane in true and in complemented form. Each of the `N_TERM` product terms picks one of four choices for every input. Each of the `N_OUT` sum terms then ORs together any chosen set of product terms, so one product term can feed several outputs.

Each output has its own polarity bit. When the bit is set, the sum is inverted, which lets the array build a function from the product terms of its complement. Each output also has a select bit that takes it either straight from the logic or from a flip-flop. The flip-flop loads the logic result on every clock edge, so the array can also build state machines.

Software loads the table through a single write port. The rows are minimised offline before they are written. Combinational outputs follow a new setting as soon as the register write has taken effect. Registered outputs follow it one clock edge later.

Top module: `pla_array`

## Requirements
- R1: Each input `i` has a 2-bit field in a product row at bits [2i+1:2i], encoded as follows: 0 is don't-care, 1 is the true literal, 2 is the complemented literal, and 3 forces the product term to 0.
- R2: A product term contributes 0 to every sum in either of two cases: its enable bit (bit 2·N_IN of the row) is clear, or none of its literal fields is connected.
- R3: Sum row `m` ORs the product terms whose bits are set in it (bit p selects term p). One term may appear in several sum rows, and an empty row yields 0 before polarity.
- R4: Polarity bit `m` of the control word (bits [N_OUT-1:0]) inverts output `m` when it is 1 and passes the sum unchanged when it is 0.
- R5: When register-select bit `m` of the control word (bits [2·N_OUT-1:N_OUT]) is 1, output `m` shows the combinational result captured at the previous rising clock edge.
- R6: When register-select bit `m` is 0, output `m` follows the inputs in the same cycle, with no clock edge.
- R7: The write address picks the register: addresses 0..N_TERM-1 are product rows, N_TERM..N_TERM+N_OUT-1 are sum rows, and N_TERM+N_OUT is the control word. A write takes effect at the rising edge where `cfg_we` is high.
- R8: While `rst_n` is low, all output flip-flops read 0 and every row and the control word are cleared, so every output reads 0.
- R9: With three inputs (input 2 is the most significant), terms A·C, B·C and A·B', and true polarity, the outputs realise F1 = Σm(3,5,7) and F2 = Σm(4,5,7).
- R10: Four terms are programmed: A·B, A'·B', B·C' and A·C'. The first sum row uses A·B, B·C' and A·C'; the second uses A'·B', B·C' and A·C'. The two complement-mode outputs then realise f1 = Σm(0,1,3,5) and f2 = Σm(3,5,7).
- R11: Values presented with `cfg_we` low, and writes to addresses above the control word, change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration and output flip-flops |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration registers |
| cfg_addr | input | ADDR_W | Register address: product rows, then sum rows, then the control word |
| cfg_wdata | input | DATA_W | Write data, LSB-aligned for each register |
| in_vec | input | N_IN | Logic inputs; bit 0 is the least significant minterm bit |
| out_vec | output | N_OUT | Function outputs |

## Verification
The assertions check the following on every cycle:
- a product row holding a forcing field, or a disabled or unconnected term, never drives its term high;
- an empty sum row gives a zero sum;
- polarity sets whether a combinational output equals its sum;
- a registered output equals the previous cycle's result;
- written rows land at their addresses, and the table holds steady without a write.

Only the bench's scenarios can show that whole functions are realised correctly, including the shared-term complement example. The same holds for the exact latency of a registered output after an input change, and for an ignored strobe or an unmapped address leaving all eight minterms unchanged.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    LIT_OPEN = 2'd0,
    LIT_TRUE = 2'd1,
    LIT_COMP = 2'd2,
    LIT_KILL = 2'd3
  } lit_e;

  function automatic int max3(input int a, input int b, input int c);
    int r;
    r = a;
    if (b > r) r = b;
    if (c > r) r = c;
    return r;
  endfunction

endpackage

// File: rtl/pla_cfg_regs.sv
module pla_cfg_regs #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 7
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [ADDR_W-1:0]                    cfg_addr,
  input  logic [DATA_W-1:0]                    cfg_wdata,
  output logic [N_TERM-1:0][2*N_IN:0]          and_cfg,
  output logic [N_OUT-1:0][N_TERM-1:0]         or_cfg,
  output logic [2*N_OUT-1:0]                   ctl_cfg
);

  localparam int AND_W    = 2 * N_IN + 1;
  localparam int CTL_W    = 2 * N_OUT;
  localparam int CTL_ADDR = N_TERM + N_OUT;

  // product rows
  for (genvar p = 0; p < N_TERM; p++) begin : g_and_row
    logic             row_en;
    logic [AND_W-1:0] row_d;

    always_comb begin
      row_en = cfg_we && (cfg_addr == ADDR_W'(p));
      row_d  = cfg_wdata[AND_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        and_cfg[p] <= '0;
      end else if (row_en) begin
        and_cfg[p] <= row_d;
      end
    end
  end

  // sum rows
  for (genvar m = 0; m < N_OUT; m++) begin : g_or_row
    logic              row_en;
    logic [N_TERM-1:0] row_d;

    always_comb begin
      row_en = cfg_we && (cfg_addr == ADDR_W'(N_TERM + m));
      row_d  = cfg_wdata[N_TERM-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        or_cfg[m] <= '0;
      end else if (row_en) begin
        or_cfg[m] <= row_d;
      end
    end
  end

  // control word: polarity and register select
  logic             ctl_en;
  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_en = cfg_we && (cfg_addr == ADDR_W'(CTL_ADDR));
    ctl_d  = cfg_wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_cfg <= '0;
    end else if (ctl_en) begin
      ctl_cfg <= ctl_d;
    end
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4
) (
  input  logic [N_IN-1:0]               in_vec,
  input  logic [N_TERM-1:0][2*N_IN:0]   and_cfg,
  output logic [N_TERM-1:0]             term_vec
);

  localparam int EN_BIT = 2 * N_IN;

  for (genvar p = 0; p < N_TERM; p++) begin : g_term
    logic hit;
    logic used;

    always_comb begin
      hit  = and_cfg[p][EN_BIT];
      used = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
        unique case (lit_e'(and_cfg[p][2*i +: 2]))
          LIT_OPEN: ;
          LIT_TRUE: begin used = 1'b1; hit = hit & in_vec[i];  end
          LIT_COMP: begin used = 1'b1; hit = hit & ~in_vec[i]; end
          LIT_KILL: begin used = 1'b1; hit = 1'b0;             end
        endcase
      end
      term_vec[p] = hit & used;
    end
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2
) (
  input  logic [N_TERM-1:0]             term_vec,
  input  logic [N_OUT-1:0][N_TERM-1:0]  or_cfg,
  input  logic [N_OUT-1:0]              pol,
  output logic [N_OUT-1:0]              sum_vec,
  output logic [N_OUT-1:0]              comb_vec
);

  for (genvar m = 0; m < N_OUT; m++) begin : g_sum
    always_comb begin
      sum_vec[m]  = |(term_vec & or_cfg[m]);
      comb_vec[m] = sum_vec[m] ^ pol[m];
    end
  end

endmodule

// File: rtl/pla_out_stage.sv
module pla_out_stage #(
  parameter int N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] comb_vec,
  input  logic [N_OUT-1:0] reg_sel,
  output logic [N_OUT-1:0] out_vec
);

  logic [N_OUT-1:0] q_nxt;
  logic [N_OUT-1:0] q_r;

  always_comb begin
    q_nxt = comb_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_nxt;
    end
  end

  for (genvar m = 0; m < N_OUT; m++) begin : g_sel
    always_comb begin
      out_vec[m] = reg_sel[m] ? q_r[m] : comb_vec[m];
    end
  end

endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  localparam int ADDR_W = $clog2(N_TERM + N_OUT + 1),
  localparam int DATA_W = max3(2 * N_IN + 1, N_TERM, 2 * N_OUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_OUT-1:0]  out_vec
);

  logic [N_TERM-1:0][2*N_IN:0]  and_cfg;
  logic [N_OUT-1:0][N_TERM-1:0] or_cfg;
  logic [2*N_OUT-1:0]           ctl_cfg;
  logic [N_OUT-1:0]             pol;
  logic [N_OUT-1:0]             reg_sel;
  logic [N_TERM-1:0]            term_vec;
  logic [N_OUT-1:0]             sum_vec;
  logic [N_OUT-1:0]             comb_vec;

  always_comb begin
    pol     = ctl_cfg[N_OUT-1:0];
    reg_sel = ctl_cfg[2*N_OUT-1:N_OUT];
  end

  pla_cfg_regs #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .and_cfg(and_cfg), .or_cfg(or_cfg), .ctl_cfg(ctl_cfg)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_vec(in_vec), .and_cfg(and_cfg), .term_vec(term_vec)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term_vec(term_vec), .or_cfg(or_cfg), .pol(pol),
    .sum_vec(sum_vec), .comb_vec(comb_vec)
  );

  pla_out_stage #(.N_OUT(N_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .comb_vec(comb_vec),
    .reg_sel(reg_sel), .out_vec(out_vec)
  );

endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 7
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_we,
  input logic [ADDR_W-1:0]             cfg_addr,
  input logic [DATA_W-1:0]             cfg_wdata,
  input logic [N_OUT-1:0]              out_vec,
  input logic [N_TERM-1:0][2*N_IN:0]   and_cfg,
  input logic [N_OUT-1:0][N_TERM-1:0]  or_cfg,
  input logic [2*N_OUT-1:0]            ctl_cfg,
  input logic [N_TERM-1:0]             term_vec,
  input logic [N_OUT-1:0]              sum_vec,
  input logic [N_OUT-1:0]              comb_vec
);

  localparam int AND_W = 2 * N_IN + 1;

  function automatic logic row_has_kill(input logic [AND_W-1:0] row);
    logic k;
    k = 1'b0;
    for (int i = 0; i < N_IN; i++) if (row[2*i +: 2] == 2'b11) k = 1'b1;
    return k;
  endfunction

  function automatic logic row_dead(input logic [AND_W-1:0] row);
    return !row[AND_W-1] || (row[AND_W-2:0] == '0);
  endfunction

  for (genvar p = 0; p < N_TERM; p++) begin : g_p
    // R1: a forcing literal field keeps the term low
    p_kill_lit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      row_has_kill(and_cfg[p]) |-> !term_vec[p]);
    // R2: disabled or unconnected terms stay low
    p_dead_term_r2: assert property (@(posedge clk) disable iff (!rst_n)
      row_dead(and_cfg[p]) |-> !term_vec[p]);
    // R7: a product-row write lands at its address
    p_and_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == ADDR_W'(p)) |=> and_cfg[p] == $past(cfg_wdata[AND_W-1:0]));
  end

  for (genvar m = 0; m < N_OUT; m++) begin : g_m
    // R3: empty sum row gives zero sum
    p_empty_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (or_cfg[m] == '0) |-> !sum_vec[m]);
    // R4: polarity decides whether a combinational output matches its sum
    p_true_pol_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_cfg[N_OUT+m] && !ctl_cfg[m]) |-> out_vec[m] == sum_vec[m]);
    p_comp_pol_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_cfg[N_OUT+m] && ctl_cfg[m]) |-> out_vec[m] != sum_vec[m]);
    // R5: registered output shows the previous cycle's result
    p_reg_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_cfg[N_OUT+m] && $past(rst_n)) |-> out_vec[m] == $past(comb_vec[m]));
    // R7: a sum-row write lands at its address
    p_or_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == ADDR_W'(N_TERM + m)) |=> or_cfg[m] == $past(cfg_wdata[N_TERM-1:0]));
  end

  // R11: without a strobe the table does not move
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(and_cfg) && $stable(or_cfg) && $stable(ctl_cfg)));

endmodule

bind pla_array pla_array_chk #(
  .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .out_vec(out_vec), .and_cfg(and_cfg),
  .or_cfg(or_cfg), .ctl_cfg(ctl_cfg), .term_vec(term_vec),
  .sum_vec(sum_vec), .comb_vec(comb_vec)
);

// File: tb/pla_array_bench.sv
module pla_array_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NI = 3;
  localparam int NT = 4;
  localparam int NO = 2;
  localparam int AW = 3;
  localparam int DW = 7;
  localparam int CTL_ADDR = NT + NO;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [DW-1:0] cfg_wdata;
  logic [NI-1:0] in_vec;
  logic [NO-1:0] out_vec;

  int n_vec = 0;
  int n_bad = 0;

  // bench copy of the program table
  logic [DW-1:0] m_and [NT];
  logic [NT-1:0] m_or  [NO];
  logic [3:0]    m_ctl;

  always #5 clk = ~clk;

  pla_array u_pla_array (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_vec(in_vec), .out_vec(out_vec)
  );

  function automatic logic [NO-1:0] model(input logic [NI-1:0] x);
    logic [NT-1:0] t;
    logic [NO-1:0] r;
    for (int p = 0; p < NT; p++) begin
      logic v, any;
      v = m_and[p][2*NI];
      any = 1'b0;
      for (int i = 0; i < NI; i++) begin
        case (m_and[p][2*i +: 2])
          2'd1: begin any = 1'b1; v = v & x[i];  end
          2'd2: begin any = 1'b1; v = v & ~x[i]; end
          2'd3: begin any = 1'b1; v = 1'b0;      end
          default: ;
        endcase
      end
      t[p] = v & any;
    end
    for (int m = 0; m < NO; m++) r[m] = (|(t & m_or[m])) ^ m_ctl[m];
    return r;
  endfunction

  task automatic chk(input string req, input logic [NO-1:0] got, input logic [NO-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = AW'(addr);
    cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < NT) m_and[addr] = data;
    else if (addr < NT + NO) m_or[addr - NT] = data[NT-1:0];
    else if (addr == CTL_ADDR) m_ctl = data[3:0];
  endtask

  task automatic clear_model();
    for (int p = 0; p < NT; p++) m_and[p] = '0;
    for (int m = 0; m < NO; m++) m_or[m] = '0;
    m_ctl = '0;
  endtask

  // sweep all minterms in combinational mode against the bench model
  task automatic sweep_model(input string req);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      in_vec = NI'(v);
      #2;
      chk(req, out_vec, model(NI'(v)));
    end
  endtask

  // sweep against explicit minterm masks
  task automatic sweep_mask(input string req, input logic [7:0] mk0, input logic [7:0] mk1);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      in_vec = NI'(v);
      #2;
      chk(req, out_vec, {mk1[v], mk0[v]});
    end
  endtask

  task automatic t_reset();
    // R8: everything cleared out of reset
    sweep_mask("R8 reset state", 8'h00, 8'h00);
  endtask

  task automatic t_example_true();
    wr(0, 7'b1_01_00_01); // A C
    wr(1, 7'b1_00_01_01); // B C
    wr(2, 7'b1_01_10_00); // A B'
    wr(3, 7'b0_00_00_00);
    wr(4, 7'b000_0011);
    wr(5, 7'b000_0101);   // term 0 shared (R3)
    wr(CTL_ADDR, 7'b000_0000);
    sweep_mask("R9 F1/F2 true form, R3 shared term", 8'hA8, 8'hB0);
  endtask

  task automatic t_example_comp();
    wr(0, 7'b1_01_01_00); // A B
    wr(1, 7'b1_10_10_00); // A' B'
    wr(2, 7'b1_00_01_10); // B C'
    wr(3, 7'b1_01_00_10); // A C'
    wr(4, 7'b000_1101);
    wr(5, 7'b000_1110);
    wr(CTL_ADDR, 7'b000_0011);
    sweep_mask("R10 complement form, R4 polarity", 8'h2B, 8'hA8);
    // R7: a control-word write alone flips the polarity back
    wr(CTL_ADDR, 7'b000_0000);
    sweep_mask("R7 control word, R4 true polarity", 8'hD4, 8'h57);
  endtask

  task automatic t_literals();
    wr(0, 7'b1_01_00_00); // A true
    wr(1, 7'b1_00_10_00); // B complement
    wr(2, 7'b1_00_00_00); // no literal, enabled
    wr(3, 7'b1_01_00_11); // forced low
    wr(4, 7'b000_0101);
    wr(5, 7'b000_1010);
    wr(CTL_ADDR, 7'b000_0000);
    sweep_mask("R1 literal codes, R2 empty term", 8'hF0, 8'h33);
    wr(1, 7'b0_00_10_00); // disabled term
    sweep_mask("R2 disabled term", 8'hF0, 8'h00);
    wr(1, 7'b1_00_10_00);
    sweep_model("R1 model sweep");
  endtask

  task automatic t_registered();
    logic [NI-1:0] prev;
    wr(CTL_ADDR, 7'b000_1000); // output 1 registered
    @(negedge clk);
    in_vec = '0;
    prev = '0;
    @(negedge clk);
    for (int v = 1; v < 8; v++) begin
      logic [NO-1:0] e_now, e_prev;
      in_vec = NI'(v);
      #2;
      e_now = model(NI'(v));
      e_prev = model(prev);
      chk("R6 combinational output same cycle", {1'b0, out_vec[0]}, {1'b0, e_now[0]});
      chk("R5 registered output holds before edge", {1'b0, out_vec[1]}, {1'b0, e_prev[1]});
      @(negedge clk);
      #1;
      chk("R5 registered output after edge", {1'b0, out_vec[1]}, {1'b0, e_now[1]});
      prev = NI'(v);
    end
    wr(CTL_ADDR, 7'b000_0000);
  endtask

  task automatic t_ignored();
    logic [NO-1:0] e;
    @(negedge clk);
    in_vec = 3'b100;
    e = model(3'b100);
    cfg_we = 1'b0;
    cfg_addr = AW'(NT);
    cfg_wdata = '0;
    @(negedge clk);
    cfg_addr = AW'(CTL_ADDR);
    cfg_wdata = '1;
    @(negedge clk);
    #1;
    chk("R11 strobe low ignored", out_vec, e);
    wr(7, '1);                 // unmapped address
    #1;
    chk("R11 unmapped address ignored", out_vec, e);
    sweep_model("R11 table intact");
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    in_vec = 3'b111;
    rst_n = 1'b0;
    #2;
    chk("R8 outputs low in reset", out_vec, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    sweep_mask("R8 table cleared by reset", 8'h00, 8'h00);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0;
    cfg_addr = '0;
    cfg_wdata = '0;
    in_vec = '0;
    clear_model();
    repeat (3) @(negedge clk);
    #1;
    chk("R8 output during reset", out_vec, 2'b00);
    rst_n = 1'b1;
    t_reset();
    t_example_true();
    t_example_comp();
    t_literals();
    t_registered();
    t_ignored();
    t_mid_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule